// File: doc/BRIEF.md
# Triplicated Memory Scrub Tester

This block exercises on-chip RAM for radiation-induced upsets. A free-running data counter supplies one word per address, and every word is stored in three independent banks at the same address. After a programmable soak interval the banks are read back, each copy is compared with the value the counter produced, and the three copies are majority-voted. Disagreements are counted per copy (correctable events) and separately for the voted word (uncorrectable events).

A host starts a run with a one-cycle pulse and reads the counters once the run is done. The counters accumulate over runs until a clear pulse, so one long irradiation can be split into many runs at different clock frequencies. An upset-injection input flips chosen bits in chosen banks at one address while the word is being written, which lets the counting path be proven before beam time.

Top module: `tmr_scrub_tester`

## Requirements
- R1: After reset or clear, busy_o and done_o are 0 and every error counter reads 0.
- R2: A start_i pulse while idle or done begins a run; busy_o is then high for exactly 2*2^N + S + 2 cycles, S being soak_cycles_i sampled at start, after which done_o stays high and busy_o low until the next start or clear.
- R3: The k-th word written since the last clear equals k modulo 2^W, and the same word goes to all three banks; with no injection a run adds no errors.
- R4: When exactly one bank holds a wrong word at an address, that bank's counter rises by one and no other counter changes.
- R5: When two or three banks hold the same wrong word at an address, each affected bank's counter and the uncorrectable counter rise by one.
- R6: Counters are not reset by start_i; they accumulate across runs and change by at most one per cycle.
- R7: Every counter saturates at 2^CW-1.
- R8: clear_i at any time, also mid-run, returns the sequencer to idle and zeroes all counters and the data counter; it has priority over start_i.
- R9: start_i while busy_o is high has no effect on the running test.
- R10: With upset_en_i high during a run, the word written at address upset_addr_i into bank b is XORed with upset_mask_i wherever bit b of upset_banks_i is 1; a zero mask causes no error. Bank b's counter sits at err_copy_o[b*CW +: CW].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-run pulse |
| clear_i | input | 1 | Abort run and zero counters |
| soak_cycles_i | input | SW | Soak length between write and read phases |
| upset_en_i | input | 1 | Enable upset injection |
| upset_addr_i | input | N | Address receiving the injected upset |
| upset_banks_i | input | 3 | Banks receiving the upset, bit b = bank b |
| upset_mask_i | input | W | Bits flipped in the injected word |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, counters final |
| err_copy_o | output | 3*CW | Per-bank mismatch counters |
| err_unc_o | output | CW | Voted-word mismatch counter |

## Verification
A wrong data or expected-value counter shows up as nonzero counters after a run with no injection, read as soon as done_o rises. A sequencer that skips or repeats an address, or mishandles the soak count, changes the busy_o length, which the bench measures to the cycle on every run. A voter or comparator fault moves the wrong counter by one in the run whose injection pattern exposes it, and a saturation fault appears at the run that crosses the counter limit.

// File: rtl/tmr_scrub_pkg.sv
package tmr_scrub_pkg;
  localparam int unsigned NCOPY = 3;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_READ  = 3'd3,
    ST_DONE  = 3'd4
  } scrub_state_e;
endpackage

// File: rtl/tmr_ram_bank.sv
module tmr_ram_bank #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] c_i,
  output logic [DW-1:0] y_o
);
  assign y_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (clr_i)               cnt_o <= '0;
    else if (inc_i && !(&cnt_o))  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tmr_scrub_tester.sv
module tmr_scrub_tester
  import tmr_scrub_pkg::*;
#(
  parameter int unsigned N  = 9,
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned SW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic [SW-1:0]     soak_cycles_i,
  input  logic              upset_en_i,
  input  logic [N-1:0]      upset_addr_i,
  input  logic [2:0]        upset_banks_i,
  input  logic [W-1:0]      upset_mask_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [3*CW-1:0]   err_copy_o,
  output logic [CW-1:0]     err_unc_o
);
  scrub_state_e  state_q;
  logic [N-1:0]  addr_q;
  logic [SW-1:0] soak_q, wait_q;
  logic [W-1:0]  dctr_q, ectr_q, cmp_exp_q;
  logic          rd_fin_q, cmp_vld_q, cmp_last_q;

  logic          wr_en, rd_issue, addr_last;
  logic [W-1:0]  rdata [NCOPY];
  logic [W-1:0]  voted;
  logic [NCOPY-1:0] copy_bad;

  assign wr_en     = (state_q == ST_WRITE);
  assign rd_issue  = (state_q == ST_READ) && !rd_fin_q;
  assign addr_last = &addr_q;
  assign busy_o    = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o    = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      soak_q     <= '0;
      wait_q     <= '0;
      dctr_q     <= '0;
      ectr_q     <= '0;
      cmp_exp_q  <= '0;
      rd_fin_q   <= 1'b0;
      cmp_vld_q  <= 1'b0;
      cmp_last_q <= 1'b0;
    end else if (clear_i) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      dctr_q     <= '0;
      rd_fin_q   <= 1'b0;
      cmp_vld_q  <= 1'b0;
      cmp_last_q <= 1'b0;
    end else begin
      cmp_vld_q  <= rd_issue;
      cmp_last_q <= rd_issue && addr_last;
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            state_q <= ST_WRITE;
            addr_q  <= '0;
            soak_q  <= soak_cycles_i;
            ectr_q  <= dctr_q;
          end
        end
        ST_WRITE: begin
          dctr_q <= dctr_q + 1'b1;
          addr_q <= addr_q + 1'b1;
          if (addr_last) begin
            state_q <= ST_WAIT;
            wait_q  <= '0;
          end
        end
        ST_WAIT: begin
          if (wait_q == soak_q) begin
            state_q  <= ST_READ;
            rd_fin_q <= 1'b0;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        ST_READ: begin
          if (rd_issue) begin
            addr_q    <= addr_q + 1'b1;
            ectr_q    <= ectr_q + 1'b1;
            cmp_exp_q <= ectr_q;
            if (addr_last) rd_fin_q <= 1'b1;
          end
          // last read word compared on this edge
          if (cmp_vld_q && cmp_last_q) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar b = 0; b < NCOPY; b++) begin : g_bank
    logic [W-1:0] wdata;
    logic         hit;
    assign hit   = upset_en_i && (addr_q == upset_addr_i) && upset_banks_i[b];
    assign wdata = dctr_q ^ (hit ? upset_mask_i : '0);

    tmr_ram_bank #(.AW(N), .DW(W)) u_bank (
      .clk_i   (clk_i),
      .we_i    (wr_en),
      .addr_i  (addr_q),
      .wdata_i (wdata),
      .rdata_o (rdata[b])
    );

    assign copy_bad[b] = cmp_vld_q && (rdata[b] != cmp_exp_q);

    sat_counter #(.CW(CW)) u_copy_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clear_i),
      .inc_i  (copy_bad[b]),
      .cnt_o  (err_copy_o[b*CW +: CW])
    );
  end

  tmr_voter #(.DW(W)) u_voter (
    .a_i (rdata[0]),
    .b_i (rdata[1]),
    .c_i (rdata[2]),
    .y_o (voted)
  );

  sat_counter #(.CW(CW)) u_unc_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clear_i),
    .inc_i  (cmp_vld_q && (voted != cmp_exp_q)),
    .cnt_o  (err_unc_o)
  );
endmodule

// File: rtl/tmr_scrub_tester_chk.sv
module tmr_scrub_tester_chk #(
  parameter int unsigned N  = 9,
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned SW = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            clear_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [3*CW-1:0] err_copy_o,
  input logic [CW-1:0]   err_unc_o
);
  p_busy_done_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  p_done_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i && !clear_i |=> done_o);

  p_clear_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !busy_o && !done_o && (err_unc_o == '0) && (err_copy_o == '0));

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !clear_i |=> busy_o || done_o);

  p_unc_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (err_unc_o == $past(err_unc_o)) || (err_unc_o == $past(err_unc_o) + 1'b1));

  p_unc_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&err_unc_o) && !clear_i |=> &err_unc_o);

  for (genvar b = 0; b < 3; b++) begin : g_copy
    p_copy_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clear_i |=> (err_copy_o[b*CW +: CW] == $past(err_copy_o[b*CW +: CW])) ||
                   (err_copy_o[b*CW +: CW] == $past(err_copy_o[b*CW +: CW]) + 1'b1));
    p_copy_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&err_copy_o[b*CW +: CW]) && !clear_i |=> &err_copy_o[b*CW +: CW]);
  end
endmodule

bind tmr_scrub_tester tmr_scrub_tester_chk #(.N(N), .W(W), .CW(CW), .SW(SW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .clear_i    (clear_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_copy_o (err_copy_o),
  .err_unc_o  (err_unc_o)
);

// File: tb/sim_tmr_scrub_tester.sv
module sim_tmr_scrub_tester;
  localparam int N  = 9;
  localparam int W  = 16;
  localparam int CW = 4;
  localparam int SW = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, clear_i = 1'b0;
  logic [SW-1:0] soak_cycles_i = '0;
  logic upset_en_i = 1'b0;
  logic [N-1:0] upset_addr_i = '0;
  logic [2:0] upset_banks_i = '0;
  logic [W-1:0] upset_mask_i = '0;
  logic busy_o, done_o;
  logic [3*CW-1:0] err_copy_o;
  logic [CW-1:0] err_unc_o;

  int tests = 0, fails = 0;
  int exp_copy [3];
  int exp_unc;
  int cycles = 0;

  always #10 clk = ~clk;

  tmr_scrub_tester #(.N(N), .W(W), .CW(CW), .SW(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .clear_i(clear_i),
    .soak_cycles_i(soak_cycles_i), .upset_en_i(upset_en_i),
    .upset_addr_i(upset_addr_i), .upset_banks_i(upset_banks_i),
    .upset_mask_i(upset_mask_i), .busy_o(busy_o), .done_o(done_o),
    .err_copy_o(err_copy_o), .err_unc_o(err_unc_o)
  );

  function automatic int sat_inc(input int v);
    return (v >= MAXC) ? MAXC : v + 1;
  endfunction

  function automatic int run_len(input int soak);
    return 2 * (1 << N) + soak + 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_counters(input string req);
    for (int b = 0; b < 3; b++)
      chk(int'(err_copy_o[b*CW +: CW]) == exp_copy[b], req, int'(err_copy_o[b*CW +: CW]), exp_copy[b]);
    chk(int'(err_unc_o) == exp_unc, req, int'(err_unc_o), exp_unc);
  endtask

  task automatic model_clear();
    for (int b = 0; b < 3; b++) exp_copy[b] = 0;
    exp_unc = 0;
  endtask

  // R4 R5 R10: expected counter movement for one injected address
  task automatic model_run(input bit en, input bit [2:0] banks, input logic [W-1:0] mask);
    int hits;
    hits = 0;
    if (en && mask != '0) begin
      for (int b = 0; b < 3; b++)
        if (banks[b]) begin
          exp_copy[b] = sat_inc(exp_copy[b]);
          hits++;
        end
      if (hits >= 2) exp_unc = sat_inc(exp_unc);
    end
  endtask

  task automatic do_run(input int soak, input bit en, input int addr, input bit [2:0] banks,
                        input logic [W-1:0] mask, input bit mid_start, input string req);
    int cyc;
    @(negedge clk);
    soak_cycles_i = SW'(soak);
    upset_en_i = en;
    upset_addr_i = N'(addr);
    upset_banks_i = banks;
    upset_mask_i = mask;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    while (busy_o && cyc < 5000) begin
      cyc++;
      start_i = (mid_start && cyc == 50);  // R9 start during run
      @(negedge clk);
    end
    start_i = 1'b0;
    upset_en_i = 1'b0;
    chk(cyc == run_len(soak), mid_start ? "R9 run length" : "R2 run length", cyc, run_len(soak));
    chk(done_o == 1'b1, "R2 done", int'(done_o), 1);
    model_run(en, banks, mask);
    chk_counters(req);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin : main
    int seed_dummy;
    seed_dummy = $urandom(32'd7219);
    model_clear();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o, "R1 flags", int'({busy_o, done_o}), 0);
    chk_counters("R1 counters");

    // R3 clean runs, also across runs
    do_run(0, 1'b0, 0, 3'b000, '0, 1'b0, "R3 clean");
    do_run(7, 1'b0, 0, 3'b000, '0, 1'b0, "R3 clean second");
    // R2 done held
    repeat (5) @(negedge clk);
    chk(done_o && !busy_o, "R2 done held", int'(done_o), 1);

    // R4 single bank upsets, R10 field positions
    do_run(3, 1'b1, 0,   3'b001, 16'h0001, 1'b0, "R4 bank0");
    do_run(1, 1'b1, 511, 3'b010, 16'h8000, 1'b0, "R4 bank1");
    do_run(2, 1'b1, 200, 3'b100, 16'hffff, 1'b0, "R4 bank2");
    // R5 two and three banks
    do_run(0, 1'b1, 17,  3'b011, 16'h00f0, 1'b0, "R5 two banks");
    do_run(5, 1'b1, 300, 3'b111, 16'h1234, 1'b0, "R5 three banks");
    // R10 zero mask has no effect
    do_run(0, 1'b1, 44,  3'b111, 16'h0000, 1'b0, "R10 zero mask");
    // R9 start while busy, R6 accumulation
    do_run(4, 1'b1, 9,   3'b101, 16'h0400, 1'b1, "R9 R6 mid start");

    // R8 clear mid-run
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (300) @(negedge clk);
    clear_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    start_i = 1'b0;
    model_clear();
    chk(!busy_o && !done_o, "R8 abort", int'({busy_o, done_o}), 0);
    chk_counters("R8 cleared");
    // R3 data counter restarts: clean run still error-free
    do_run(0, 1'b0, 0, 3'b000, '0, 1'b0, "R8 R3 after clear");

    // random runs
    for (int i = 0; i < 14; i++) begin
      do_run(int'($urandom % 20), ($urandom % 4) != 0, int'($urandom % (1 << N)),
             3'($urandom), (($urandom % 3) == 0) ? 16'h0000 : 16'($urandom), 1'b0, "R6 random");
    end

    // R7 saturation on bank1 only
    for (int i = 0; i < 17; i++)
      do_run(0, 1'b1, i * 13, 3'b010, 16'h0101, 1'b0, "R7 saturate");
    chk(int'(err_copy_o[CW +: CW]) == MAXC, "R7 bank1 at max", int'(err_copy_o[CW +: CW]), MAXC);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule